// File: doc/BRIEF.md
# Core Sleep and Event Controller

This block decides, cycle by cycle, whether a processor core keeps fetching or stops with its clock gated off. Three requests can put the core to sleep: a wait-for-interrupt request, a wait-for-event request, and a return from an exception to thread mode while the sleep-on-exit control bit is set. Each sleep ends on its own set of wake conditions. When the core wakes, or when a request completes without any sleep, the block raises a one-cycle `resume` pulse so that fetch can continue.

A one-bit event latch records send-event pulses and external event pulses. A wait-for-event that finds the latch set returns at once and clears it. When the send-event-on-pend control bit is set, a newly pending interrupt line also sets the latch, even if that line is masked. A wake condition that is present in the same cycle as a sleep request wins, so the clock-gate is never asserted for a sleep that is already over. The `sleeping` and `sleepdeep` outputs let a power controller choose between normal and deep sleep.

Top module: `core_sleep_ctrl`

## Requirements
- R1: When reset is released, `core_clk_en`=1, `sleeping`=0, `sleepdeep`=0 and `resume`=0, and the event latch is clear, so a first wait-for-event with no wake source present goes to sleep.
- R2: Interrupt line i qualifies when `irq_pend[i]`=1, `irq_en[i]`=1 and its priority field `irq_prio[i*PW +: PW]` is numerically lower than `cur_prio`. A lower number means a more urgent interrupt.
- R3: A wait-for-interrupt request in the running state with no wake condition present gives `sleeping`=1 and `core_clk_en`=0 from the next cycle. The block stays asleep until a wake condition arrives.
- R4: Asleep on wait-for-interrupt, a qualifying interrupt or `dbg_halt` returns the block to the running state on the next cycle, with `resume`=1 for that one cycle. Non-qualifying interrupts and event pulses do not wake this sleep.
- R5: If a wake condition for the requested sleep kind is present in the same cycle as the request, no sleep is entered: the next cycle shows `core_clk_en`=1, `sleeping`=0 and `resume`=1.
- R6: Asleep on wait-for-event, the block wakes on a qualifying interrupt, on `dbg_halt`, on `sev_req`, or on any bit of `ext_evt`.
- R7: Pulses on `sev_req` or `ext_evt` set the event latch while the block is running or asleep on wait-for-interrupt. A wait-for-event that finds the latch set completes at once with `resume` and clears the latch, so the next wait-for-event sleeps.
- R8: In the running state, `exc_ret_thread`=1 with `ctl_sleep_on_exit`=1 acts as a wait-for-interrupt request. With `ctl_sleep_on_exit`=0 it has no effect.
- R9: With `ctl_sev_on_pend`=1, a 0-to-1 change of any `irq_pend` bit sets the event latch, even when that line is disabled. With the bit at 0, a disabled line that becomes pending does not set the latch.
- R10: `sleepdeep` equals `sleeping` AND `ctl_deep`, and follows `ctl_deep` in the same cycle.
- R11: Sleep requests that arrive while the block is asleep are ignored. When a wait-for-interrupt request and a wait-for-event request arrive in the same cycle, the wait-for-interrupt request wins and the event latch is left untouched.
- R12: Asserting reset while asleep returns the block at once to the running state with `resume`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| wfe_req | input | 1 | Wait-for-event request pulse |
| sev_req | input | 1 | Send-event pulse |
| ext_evt | input | NUM_EVT | External event pulses |
| irq_pend | input | NUM_IRQ | Pending flag of each interrupt line |
| irq_en | input | NUM_IRQ | Enable of each interrupt line |
| irq_prio | input | NUM_IRQ*PW | Priority field of each line, line i at bits [i*PW +: PW] |
| cur_prio | input | PW | Current execution priority |
| dbg_halt | input | 1 | Debug halt request |
| exc_ret_thread | input | 1 | Exception return to thread mode in this cycle |
| ctl_sleep_on_exit | input | 1 | Sleep automatically on return to thread mode |
| ctl_deep | input | 1 | Deep-sleep select |
| ctl_sev_on_pend | input | 1 | A newly pending interrupt sets the event latch |
| core_clk_en | output | 1 | Core clock enable, 0 gates the core |
| sleeping | output | 1 | Core is asleep |
| sleepdeep | output | 1 | Asleep with deep sleep selected |
| resume | output | 1 | One-cycle pulse: fetch continues |

## Verification
The critical coincidence is a sleep request that falls in the same cycle as one of its own wake conditions: a qualifying interrupt, a debug halt or an event pulse. The bench sweeps every enable, pending and priority combination against every current level for one interrupt line. It raises each combination both together with a wait-for-interrupt request and later, during an existing sleep, and expects immediate completion or a wake exactly when the line qualifies arithmetically. It also drives event pulses together with wait-for-event, and a wait-for-interrupt request together with wait-for-event, to check that the winning side gates no clock and that the event latch is consumed only by a wait-for-event that takes effect.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SLP_WFI = 2'd1,
        ST_SLP_WFE = 2'd2
    } csc_state_e;

    typedef struct packed {
        csc_state_e state;
        logic       resume;
    } csc_fsm_t;

endpackage

// File: rtl/csc_irq_qual.sv
module csc_irq_qual #(
    parameter int NUM_IRQ = 8,
    parameter int PW      = 3
) (
    input  logic [NUM_IRQ-1:0]    irq_pend,
    input  logic [NUM_IRQ-1:0]    irq_en,
    input  logic [NUM_IRQ*PW-1:0] irq_prio,
    input  logic [PW-1:0]         cur_prio,
    output logic                  irq_qual
);

    logic [NUM_IRQ-1:0] hit_d;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        logic [PW-1:0] prio_d;
        always_comb begin
            prio_d   = irq_prio[i*PW +: PW];
            hit_d[i] = irq_pend[i] & irq_en[i] & (prio_d < cur_prio);
        end
    end

    always_comb irq_qual = |hit_d;

endmodule

// File: rtl/csc_event_latch.sv
module csc_event_latch #(
    parameter int NUM_IRQ = 8,
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sev_req,
    input  logic [NUM_EVT-1:0] ext_evt,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic               sev_on_pend,
    input  logic               consume,
    output logic               latch_q,
    output logic               evt_now
);

    typedef struct packed {
        logic               latch;
        logic [NUM_IRQ-1:0] pend;
    } evl_t;

    evl_t               r_d, r_q;
    logic [NUM_IRQ-1:0] new_pend_d;

    always_comb begin
        r_d        = r_q;
        new_pend_d = irq_pend & ~r_q.pend;
        evt_now    = sev_req | (|ext_evt) | (sev_on_pend & (|new_pend_d));
        r_d.pend   = irq_pend;
        if (consume) r_d.latch = 1'b0;
        else         r_d.latch = r_q.latch | evt_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb latch_q = r_q.latch;

    p_consume_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !latch_q);

    p_pend_sets_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sev_on_pend && (|new_pend_d) && !consume) |=> latch_q);

endmodule

// File: rtl/csc_sleep_fsm.sv
module csc_sleep_fsm
    import csc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_req,
    input  logic wfe_req,
    input  logic exc_ret_thread,
    input  logic ctl_sleep_on_exit,
    input  logic irq_qual,
    input  logic dbg_halt,
    input  logic evt_now,
    input  logic latch_q,
    output logic consume,
    output logic asleep,
    output logic resume
);

    csc_fsm_t f_d, f_q;
    logic     wfi_go, wfi_wake, wfe_wake;

    always_comb begin
        f_d      = f_q;
        f_d.resume = 1'b0;
        consume  = 1'b0;
        wfi_go   = wfi_req | (exc_ret_thread & ctl_sleep_on_exit);
        wfi_wake = irq_qual | dbg_halt;
        wfe_wake = wfi_wake | evt_now;
        unique case (f_q.state)
            ST_RUN: begin
                if (wfi_go) begin
                    if (wfi_wake) f_d.resume = 1'b1;
                    else          f_d.state  = ST_SLP_WFI;
                end else if (wfe_req) begin
                    consume = 1'b1;
                    if (latch_q || wfe_wake) f_d.resume = 1'b1;
                    else                     f_d.state  = ST_SLP_WFE;
                end
            end
            ST_SLP_WFI: begin
                if (wfi_wake) begin
                    f_d.state  = ST_RUN;
                    f_d.resume = 1'b1;
                end
            end
            ST_SLP_WFE: begin
                if (wfe_wake) begin
                    f_d.state  = ST_RUN;
                    f_d.resume = 1'b1;
                    consume    = 1'b1;
                end
            end
            default: f_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: ST_RUN, resume: 1'b0};
        else        f_q <= f_d;
    end

    always_comb begin
        asleep = (f_q.state != ST_RUN);
        resume = f_q.resume;
    end

    p_wfi_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_SLP_WFI && irq_qual) |=> (!asleep && resume));

    p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_RUN && wfi_go && wfi_wake) |=> !asleep);

    p_latch_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_RUN && !wfi_go && wfe_req && latch_q) |=> (!asleep && resume));

    p_exit_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_RUN && exc_ret_thread && ctl_sleep_on_exit && !wfi_wake)
        |=> (f_q.state == ST_SLP_WFI));

    p_asleep_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_SLP_WFI && !irq_qual && !dbg_halt) |=> asleep);

endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl #(
    parameter int NUM_IRQ = 8,
    parameter int PW      = 3,
    parameter int NUM_EVT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wfi_req,
    input  logic                  wfe_req,
    input  logic                  sev_req,
    input  logic [NUM_EVT-1:0]    ext_evt,
    input  logic [NUM_IRQ-1:0]    irq_pend,
    input  logic [NUM_IRQ-1:0]    irq_en,
    input  logic [NUM_IRQ*PW-1:0] irq_prio,
    input  logic [PW-1:0]         cur_prio,
    input  logic                  dbg_halt,
    input  logic                  exc_ret_thread,
    input  logic                  ctl_sleep_on_exit,
    input  logic                  ctl_deep,
    input  logic                  ctl_sev_on_pend,
    output logic                  core_clk_en,
    output logic                  sleeping,
    output logic                  sleepdeep,
    output logic                  resume
);

    logic irq_qual, latch_q, evt_now, consume, asleep;

    csc_irq_qual #(.NUM_IRQ(NUM_IRQ), .PW(PW)) u_qual (
        .irq_pend (irq_pend),
        .irq_en   (irq_en),
        .irq_prio (irq_prio),
        .cur_prio (cur_prio),
        .irq_qual (irq_qual)
    );

    csc_event_latch #(.NUM_IRQ(NUM_IRQ), .NUM_EVT(NUM_EVT)) u_evl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sev_req     (sev_req),
        .ext_evt     (ext_evt),
        .irq_pend    (irq_pend),
        .sev_on_pend (ctl_sev_on_pend),
        .consume     (consume),
        .latch_q     (latch_q),
        .evt_now     (evt_now)
    );

    csc_sleep_fsm u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .wfi_req           (wfi_req),
        .wfe_req           (wfe_req),
        .exc_ret_thread    (exc_ret_thread),
        .ctl_sleep_on_exit (ctl_sleep_on_exit),
        .irq_qual          (irq_qual),
        .dbg_halt          (dbg_halt),
        .evt_now           (evt_now),
        .latch_q           (latch_q),
        .consume           (consume),
        .asleep            (asleep),
        .resume            (resume)
    );

    always_comb begin
        sleeping    = asleep;
        core_clk_en = ~asleep;
        sleepdeep   = asleep & ctl_deep;
    end

    p_no_deep_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sleeping |-> !sleepdeep);

    p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping |-> (!core_clk_en && !resume));

endmodule

// File: tb/sim_core_sleep_ctrl.sv
module sim_core_sleep_ctrl;

    localparam int NI = 2;
    localparam int PW = 2;
    localparam int NE = 2;
    localparam logic [3:0] RI = 4'b1000;
    localparam logic [3:0] RR = 4'b1001;
    localparam logic [3:0] SL = 4'b0100;
    localparam logic [3:0] SD = 4'b0110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi_req = 0, wfe_req = 0, sev_req = 0, dbg_halt = 0, exc_ret_thread = 0;
    logic ctl_sleep_on_exit = 0, ctl_deep = 0, ctl_sev_on_pend = 0;
    logic [NE-1:0] ext_evt = '0;
    logic [NI-1:0] irq_pend = '0, irq_en = '0;
    logic [NI*PW-1:0] irq_prio = '0;
    logic [PW-1:0] cur_prio = '0;
    logic core_clk_en, sleeping, sleepdeep, resume;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    core_sleep_ctrl #(.NUM_IRQ(NI), .PW(PW), .NUM_EVT(NE)) u0 (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .sev_req(sev_req), .ext_evt(ext_evt), .irq_pend(irq_pend), .irq_en(irq_en),
        .irq_prio(irq_prio), .cur_prio(cur_prio), .dbg_halt(dbg_halt),
        .exc_ret_thread(exc_ret_thread), .ctl_sleep_on_exit(ctl_sleep_on_exit),
        .ctl_deep(ctl_deep), .ctl_sev_on_pend(ctl_sev_on_pend),
        .core_clk_en(core_clk_en), .sleeping(sleeping), .sleepdeep(sleepdeep),
        .resume(resume)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input logic [3:0] exp);
        logic [3:0] act;
        act = {core_clk_en, sleeping, sleepdeep, resume};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act={clk_en,slp,deep,res}=%b exp=%b", rq, act, exp);
        end
    endtask

    task automatic pulse_wfi();  wfi_req = 1; cyc(); wfi_req = 0; endtask
    task automatic pulse_wfe();  wfe_req = 1; cyc(); wfe_req = 0; endtask
    task automatic pulse_sev();  sev_req = 1; cyc(); sev_req = 0; endtask
    task automatic pulse_dbg();  dbg_halt = 1; cyc(); dbg_halt = 0; endtask

    task automatic set_combo(input int pd, input int e, input int p, input int c);
        irq_pend = {1'b0, 1'(pd)};
        irq_en   = {1'b0, 1'(e)};
        irq_prio = {2'b11, 2'(p)};
        cur_prio = 2'(c);
    endtask

    task automatic clr_irq();
        irq_pend = '0; irq_en = '0; irq_prio = '0; cur_prio = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cyc();
        chk("R1 reset state", RI);
        pulse_wfe();
        chk("R1 latch clear after reset", SL);
        ext_evt = 2'b10; cyc(); ext_evt = '0;
        chk("R6 ext_evt wakes wfe", RR);
        cyc();
        chk("R4 resume is one cycle", RI);

        // R2/R5 sweep: interrupt present together with the request
        for (int pd = 0; pd < 2; pd++)
            for (int e = 0; e < 2; e++)
                for (int p = 0; p < 4; p++)
                    for (int c = 0; c < 4; c++) begin
                        bit q;
                        q = (pd == 1) && (e == 1) && (p < c);
                        set_combo(pd, e, p, c);
                        cyc();
                        pulse_wfi();
                        chk($sformatf("R5 R2 wfi pd=%0d en=%0d p=%0d c=%0d", pd, e, p, c), q ? RR : SL);
                        if (!q) begin
                            pulse_dbg();
                            chk("R4 dbg wakes wfi", RR);
                        end
                        clr_irq();
                        cyc();
                    end

        // R2/R4 sweep: interrupt arrives during sleep
        for (int pd = 0; pd < 2; pd++)
            for (int e = 0; e < 2; e++)
                for (int p = 0; p < 4; p++)
                    for (int c = 0; c < 4; c++) begin
                        bit q;
                        q = (pd == 1) && (e == 1) && (p < c);
                        pulse_wfi();
                        chk("R3 wfi sleeps", SL);
                        set_combo(pd, e, p, c);
                        cyc();
                        chk($sformatf("R4 R2 wake pd=%0d en=%0d p=%0d c=%0d", pd, e, p, c), q ? RR : SL);
                        if (!q) begin
                            pulse_dbg();
                            chk("R4 dbg wakes wfi", RR);
                        end
                        clr_irq();
                        cyc();
                    end

        // R7 send-event latch
        pulse_sev();
        chk("R7 sev alone no effect", RI);
        pulse_wfe();
        chk("R7 latched wfe returns", RR);
        pulse_wfe();
        chk("R7 latch consumed", SL);
        pulse_sev();
        chk("R6 sev wakes wfe", RR);

        // R4/R7 event during wfi sleep latches, no wake
        pulse_wfi();
        ext_evt = 2'b01; cyc(); ext_evt = '0;
        chk("R4 event does not wake wfi", SL);
        pulse_dbg();
        chk("R4 dbg wake", RR);
        pulse_wfe();
        chk("R7 latched during wfi sleep", RR);

        // R5 same-cycle event and wfe
        wfe_req = 1; ext_evt = 2'b01; cyc(); wfe_req = 0; ext_evt = '0;
        chk("R5 wfe with event same cycle", RR);
        pulse_wfe();
        chk("R5 event consumed", SL);
        set_combo(1, 1, 0, 3);
        cyc();
        chk("R6 irq wakes wfe", RR);
        clr_irq(); cyc();
        pulse_wfe();
        pulse_dbg();
        chk("R6 dbg wakes wfe", RR);
        wfi_req = 1; dbg_halt = 1; cyc(); wfi_req = 0; dbg_halt = 0;
        chk("R5 wfi with dbg same cycle", RR);

        // R8 sleep on exit
        exc_ret_thread = 1; cyc(); exc_ret_thread = 0;
        chk("R8 exit without bit", RI);
        ctl_sleep_on_exit = 1;
        exc_ret_thread = 1; cyc(); exc_ret_thread = 0;
        chk("R8 exit with bit sleeps", SL);
        pulse_dbg();
        chk("R8 wake", RR);
        ctl_sleep_on_exit = 0;

        // R9 send-event-on-pend
        ctl_sev_on_pend = 1;
        irq_pend = 2'b01; cyc();
        chk("R9 masked pend no wake", RI);
        pulse_wfe();
        chk("R9 masked pend set latch", RR);
        irq_pend = '0; cyc();
        ctl_sev_on_pend = 0;
        irq_pend = 2'b10; cyc();
        pulse_wfe();
        chk("R9 bit clear masked pend ignored", SL);
        pulse_dbg();
        irq_pend = '0; cyc();

        // R10 sleepdeep
        ctl_deep = 1; #1;
        chk("R10 deep while running", RI);
        pulse_wfi();
        chk("R10 deep sleep", SD);
        ctl_deep = 0; #1;
        chk("R10 follows ctl_deep", SL);
        ctl_deep = 1;
        pulse_dbg();
        chk("R10 wake clears deep", RR);
        ctl_deep = 0;

        // R11 requests while asleep, wfi over wfe
        pulse_wfi();
        pulse_wfe();
        chk("R11 wfe ignored asleep", SL);
        pulse_sev();
        chk("R11 asleep on wfi not wfe", SL);
        pulse_dbg();
        wfi_req = 1; wfe_req = 1; cyc(); wfi_req = 0; wfe_req = 0;
        chk("R11 wfi wins over wfe", SL);
        pulse_dbg();
        chk("R11 wake", RR);
        pulse_wfe();
        chk("R11 latch kept", RR);

        // R12 reset while asleep
        pulse_wfi();
        chk("R12 asleep", SL);
        rst_n = 0; #1;
        chk("R12 reset forces run", RI);
        cyc();
        rst_n = 1;
        cyc();
        chk("R12 run after reset", RI);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule